// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects fixed interrupt requests, each tagged with an 8-bit vector, and hands them to a processor core one at a time in priority order. Every vector has one pending bit and one in-service bit. A request is answered in its own cycle, either with an accept or with a retry. The controller keeps a task priority that software writes and derives a processor priority from it and from the highest vector currently in service. A pending vector is offered to the core only when its priority class is strictly above the processor priority class.

When the core takes the offered vector through a valid/ready handshake, the vector moves from pending to in-service. The core signals that its handler has finished with an end-of-interrupt register write, which retires the highest in-service vector. If that vector was accepted as level-triggered, the block pulses a notification output for one cycle and presents the retired vector. Both searches (highest pending and highest in service) are two-level encoders: the first level finds the class, the second finds the rank within that class.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset nothing is pending or in service, the task priority is 0, proc_prio reads 0, dsp_valid is 0 and eoi_pulse is 0.
- R2: A request with a vector from 0 to 15 gets neither req_accept nor req_retry, and it changes no state.
- R3: A request with a vector from 16 to 255 asserts req_accept in the same cycle if that vector's pending bit is clear, and the bit is set at the next edge. If the bit is already set, the request asserts req_retry instead.
- R4: dsp_vector shows the highest pending vector. The class is the vector's upper four bits and a higher class wins. Within one class, the higher lower four bits (rank) win.
- R5: proc_prio equals the task priority when the task priority's upper nibble is at least the class of the highest in-service vector. An empty in-service set counts as class 0. Otherwise proc_prio equals that class in the upper nibble with a lower nibble of 0.
- R6: dsp_valid is 1 exactly when a vector is pending and the class of the highest pending vector is strictly greater than the upper nibble of proc_prio.
- R7: In a cycle with dsp_valid and dsp_ready both high, the offered vector's pending bit clears and its in-service bit sets at that edge. From the next cycle it raises proc_prio as R5 describes.
- R8: A register write with wr_sel=1 (end of interrupt) clears the highest set in-service bit at that edge. With nothing in service, the write has no effect.
- R9: One cycle after an end-of-interrupt write retires a vector, eoi_pulse is high for one cycle with eoi_vector equal to that vector, but only if req_level was 1 when that vector was accepted. An edge-triggered vector (req_level=0) gives no pulse.
- R10: A register write with wr_sel=0 loads wr_data into the task priority, and proc_prio shows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Interrupt request present |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accept | output | 1 | Request taken this cycle |
| req_retry | output | 1 | Request refused, sender must retry |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = task priority, 1 = end of interrupt |
| wr_data | input | 8 | Task priority value |
| dsp_valid | output | 1 | A vector is offered to the core |
| dsp_vector | output | 8 | Offered vector |
| dsp_ready | input | 1 | Core takes the offered vector |
| proc_prio | output | 8 | Current processor priority |
| eoi_pulse | output | 1 | Level-triggered vector retired |
| eoi_vector | output | 8 | Vector retired by the last end-of-interrupt write |

## Verification
A wrong pending bit shows at the ports in the same cycle that a request for that vector arrives: accept and retry trade places. If that vector is the highest pending one, the error already shows in dsp_vector or dsp_valid. A stale or missing in-service bit shows as a wrong proc_prio from the next cycle, and it later gates dispatch wrongly. A lost trigger-mode bit stays hidden until the vector is retired, which can be many cycles later. The random mix therefore drives long dispatch and retire sequences so that such faults reach eoi_pulse.

// File: rtl/irq_prio_pkg.sv
// Shared definitions for the vectored interrupt priority controller.
// Assumes an 8-bit vector with a 4-bit class and a 4-bit rank.
package irq_prio_pkg;
    typedef enum logic {
        SEL_TASK_PRIO = 1'b0,
        SEL_EOI       = 1'b1
    } wr_sel_e;
endpackage

// File: rtl/irq_msb_enc.sv
// Highest-set-bit encoder over W inputs.
// Assumes W is a power of two. idx_o is 0 when nothing is set.
module irq_msb_enc #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Scan upward so that the last set bit seen is the highest one.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_find.sv
// Two-level search for the highest set bit in a per-vector bitmap.
// Level one picks the highest non-empty class. Level two picks the
// highest rank within that class.
// Assumes VEC_W > RANK_W.
module irq_prio_find #(
    parameter int VEC_W  = 8,
    parameter int RANK_W = 4,
    localparam int NVEC  = 1 << VEC_W,
    localparam int CLS_W = VEC_W - RANK_W,
    localparam int NCLS  = 1 << CLS_W,
    localparam int NRANK = 1 << RANK_W
) (
    input  logic [NVEC-1:0]  bits_i,
    output logic             found_o,
    output logic [VEC_W-1:0] idx_o
);
    logic [NCLS-1:0]   grp_any;
    logic              cls_found;
    logic [CLS_W-1:0]  cls_idx;
    logic [NRANK-1:0]  grp_bits;
    logic              rank_found;
    logic [RANK_W-1:0] rank_idx;

    // Per-class occupancy: one OR per group of NRANK vectors.
    for (genvar c = 0; c < NCLS; c++) begin : g_grp
        assign grp_any[c] = |bits_i[c*NRANK +: NRANK];
    end

    irq_msb_enc #(.W(NCLS)) u_cls_enc (
        .bits_i  (grp_any),
        .found_o (cls_found),
        .idx_o   (cls_idx)
    );

    // Select the winning class's group for the rank search.
    always_comb grp_bits = bits_i[cls_idx*NRANK +: NRANK];

    irq_msb_enc #(.W(NRANK)) u_rank_enc (
        .bits_i  (grp_bits),
        .found_o (rank_found),
        .idx_o   (rank_idx)
    );

    assign found_o = cls_found & rank_found;
    assign idx_o   = {cls_idx, rank_idx};
endmodule

// File: rtl/irq_prio_ctrl.sv
// Vectored interrupt priority controller (top).
// Keeps a pending bitmap, an in-service bitmap and a latched trigger mode
// for each vector. It offers the highest pending vector to the core when
// that vector's class beats the processor priority, and retires the
// highest in-service vector on an end-of-interrupt write.
// Assumes one request and one register write per cycle at most.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int RANK_W  = 4,
    parameter int MIN_VEC = 16,
    localparam int NVEC   = 1 << VEC_W,
    localparam int CLS_W  = VEC_W - RANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    output logic             req_accept,
    output logic             req_retry,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [VEC_W-1:0] wr_data,
    output logic             dsp_valid,
    output logic [VEC_W-1:0] dsp_vector,
    input  logic             dsp_ready,
    output logic [VEC_W-1:0] proc_prio,
    output logic             eoi_pulse,
    output logic [VEC_W-1:0] eoi_vector
);
    logic [NVEC-1:0]  pend_q, pend_d;
    logic [NVEC-1:0]  isr_q,  isr_d;
    logic [NVEC-1:0]  lvl_q,  lvl_d;
    logic [VEC_W-1:0] tpr_q;
    logic             eoi_pulse_q;
    logic [VEC_W-1:0] eoi_vec_q;

    logic             hp_found, hi_found;
    logic [VEC_W-1:0] hp_vec,   hi_vec;
    logic [CLS_W-1:0] isr_cls;
    logic             req_ok, take, eoi_hit, tpr_hit;

    irq_prio_find #(.VEC_W(VEC_W), .RANK_W(RANK_W)) u_pend_find (
        .bits_i  (pend_q),
        .found_o (hp_found),
        .idx_o   (hp_vec)
    );

    irq_prio_find #(.VEC_W(VEC_W), .RANK_W(RANK_W)) u_isr_find (
        .bits_i  (isr_q),
        .found_o (hi_found),
        .idx_o   (hi_vec)
    );

    // Processor priority: the task priority, raised to the in-service class floor.
    always_comb begin
        isr_cls = hi_found ? hi_vec[VEC_W-1 -: CLS_W] : '0;
        if (tpr_q[VEC_W-1 -: CLS_W] >= isr_cls)
            proc_prio = tpr_q;
        else
            proc_prio = {isr_cls, {RANK_W{1'b0}}};
    end

    // Request response: accept into a free pending slot, retry on an occupied one.
    always_comb begin
        req_ok     = req_valid && (req_vector >= VEC_W'(MIN_VEC));
        req_accept = req_ok && !pend_q[req_vector];
        req_retry  = req_ok &&  pend_q[req_vector];
    end

    // Dispatch offer and the decode of register writes.
    always_comb begin
        dsp_vector = hp_vec;
        dsp_valid  = hp_found &&
                     (hp_vec[VEC_W-1 -: CLS_W] > proc_prio[VEC_W-1 -: CLS_W]);
        take       = dsp_valid && dsp_ready;
        eoi_hit    = wr_en && (wr_sel == SEL_EOI) && hi_found;
        tpr_hit    = wr_en && (wr_sel == SEL_TASK_PRIO);
    end

    // Next state of the three per-vector bitmaps.
    always_comb begin
        pend_d = pend_q;
        isr_d  = isr_q;
        lvl_d  = lvl_q;
        if (eoi_hit)
            isr_d[hi_vec] = 1'b0;
        if (take) begin
            pend_d[hp_vec] = 1'b0;
            isr_d[hp_vec]  = 1'b1;
        end
        if (req_accept) begin
            pend_d[req_vector] = 1'b1;
            lvl_d[req_vector]  = req_level;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            isr_q       <= '0;
            lvl_q       <= '0;
            tpr_q       <= '0;
            eoi_pulse_q <= 1'b0;
            eoi_vec_q   <= '0;
        end else begin
            pend_q      <= pend_d;
            isr_q       <= isr_d;
            lvl_q       <= lvl_d;
            if (tpr_hit)
                tpr_q <= wr_data;
            eoi_pulse_q <= eoi_hit && lvl_q[hi_vec];
            if (eoi_hit)
                eoi_vec_q <= hi_vec;
        end
    end

    assign eoi_pulse  = eoi_pulse_q;
    assign eoi_vector = eoi_vec_q;

    AST_LOW_VEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vector < VEC_W'(MIN_VEC)) |-> (!req_accept && !req_retry)); // R2
    AST_ACCEPT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> pend_q[$past(req_vector)]); // R3
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && req_retry)); // R3
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        proc_prio[VEC_W-1 -: CLS_W] >= tpr_q[VEC_W-1 -: CLS_W]); // R5
    AST_DSP_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> (dsp_vector[VEC_W-1 -: CLS_W] > proc_prio[VEC_W-1 -: CLS_W])); // R6
    AST_TAKE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready) |=>
        (isr_q[$past(dsp_vector)] && !pend_q[$past(dsp_vector)])); // R7
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit |=> !isr_q[$past(hi_vec)]); // R8
    AST_EOI_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> $past(wr_en && wr_sel == SEL_EOI)); // R9
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_level, req_accept, req_retry;
    logic [7:0] req_vector;
    logic       wr_en, wr_sel;
    logic [7:0] wr_data;
    logic       dsp_valid, dsp_ready;
    logic [7:0] dsp_vector, proc_prio, eoi_vector;
    logic       eoi_pulse;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state
    logic [255:0] m_pend, m_isr, m_lvl;
    logic [7:0]   m_tpr;
    logic         e_p;
    int           e_v;
    int           e_hp;
    logic         e_dv, e_acc;
    logic         c_rv, c_rl, c_we, c_ws, c_rdy;
    logic [7:0]   c_vec, c_wd;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .req_accept(req_accept), .req_retry(req_retry),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dsp_valid(dsp_valid), .dsp_vector(dsp_vector), .dsp_ready(dsp_ready),
        .proc_prio(proc_prio), .eoi_pulse(eoi_pulse), .eoi_vector(eoi_vector)
    );

    function automatic int hi_of(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] exp_ppr();
        int h = hi_of(m_isr);
        int ic = (h >= 0) ? (h >> 4) : 0;
        if (int'(m_tpr[7:4]) >= ic) return m_tpr;
        return 8'(ic << 4);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs and check all outputs against the model.
    task automatic drive_chk(input logic rv, input logic [7:0] vec, input logic rl,
                             input logic we, input logic ws, input logic [7:0] wd,
                             input logic rdy);
        logic [7:0] pp;
        logic okv;
        @(negedge clk);
        req_valid = rv; req_vector = vec; req_level = rl;
        wr_en = we; wr_sel = ws; wr_data = wd; dsp_ready = rdy;
        c_rv = rv; c_vec = vec; c_rl = rl; c_we = we; c_ws = ws; c_wd = wd; c_rdy = rdy;
        #1;
        pp    = exp_ppr();
        e_hp  = hi_of(m_pend);
        e_dv  = (e_hp >= 0) && ((e_hp >> 4) > int'(pp[7:4]));
        okv   = rv && (vec >= 8'd16);
        e_acc = okv && !m_pend[vec];
        chk(vec < 8'd16 ? "R2" : "R3", req_accept, e_acc);
        chk(vec < 8'd16 ? "R2" : "R3", req_retry, okv && m_pend[vec]);
        chk("R5", proc_prio, pp);
        chk("R6", dsp_valid, e_dv);
        if (e_dv) chk("R4", dsp_vector, e_hp);
        chk("R9", eoi_pulse, e_p);
        if (e_p) chk("R9", eoi_vector, e_v);
    endtask

    // Apply the edge effect of the driven cycle to the model.
    task automatic commit();
        int h = hi_of(m_isr);
        if (c_we && c_ws && h >= 0) begin
            m_isr[h] = 1'b0;
            e_p = m_lvl[h];
            e_v = h;
        end else begin
            e_p = 1'b0;
        end
        if (e_dv && c_rdy) begin
            m_pend[e_hp] = 1'b0;
            m_isr[e_hp]  = 1'b1;
        end
        if (e_acc) begin
            m_pend[c_vec] = 1'b1;
            m_lvl[c_vec]  = c_rl;
        end
        if (c_we && !c_ws) m_tpr = c_wd;
    endtask

    task automatic step(input logic rv, input logic [7:0] vec, input logic rl,
                        input logic we, input logic ws, input logic [7:0] wd,
                        input logic rdy);
        drive_chk(rv, vec, rl, we, ws, wd, rdy);
        commit();
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] pick [8];
        pick = '{8'h20, 8'h21, 8'h35, 8'h4f, 8'h80, 8'hff, 8'h10, 8'h0f};
        void'($urandom(32'd4242));
        m_pend = '0; m_isr = '0; m_lvl = '0; m_tpr = '0; e_p = 1'b0; e_v = 0;
        rst_n = 1'b0;
        req_valid = 0; req_vector = 0; req_level = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0; dsp_ready = 0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); #1;
        chk("R1", dsp_valid, 0);
        chk("R1", proc_prio, 0);
        chk("R1", eoi_pulse, 0);

        // R2: low vector ignored
        step(1, 8'h05, 1, 0, 0, 0, 1);
        drive_chk(0, 0, 0, 0, 0, 0, 1);
        chk("R2", dsp_valid, 0);
        commit();

        // R10: task priority write
        step(0, 0, 0, 1, 0, 8'h30, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R10", proc_prio, 8'h30);
        commit();

        // R6: class 2 blocked by task priority class 3
        step(1, 8'h25, 0, 0, 0, 0, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R6", dsp_valid, 0);
        commit();

        // R3 / R4: accept, retry duplicate, ordering
        step(1, 8'h50, 1, 0, 0, 0, 0);
        step(1, 8'h50, 1, 0, 0, 0, 0);
        step(1, 8'h45, 0, 0, 0, 0, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R4", dsp_vector, 8'h50);
        commit();

        // R7: handshake moves 0x50 into service, blocking 0x45
        step(0, 0, 0, 0, 0, 0, 1);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R7", proc_prio, 8'h50);
        chk("R7", dsp_valid, 0);
        commit();

        // R8 / R9: retire level-triggered 0x50
        step(0, 0, 0, 1, 1, 0, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R9", eoi_pulse, 1);
        chk("R8", dsp_valid, 1);
        chk("R8", dsp_vector, 8'h45);
        commit();

        // R9: edge-triggered 0x45 retires silently
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1, 0, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R9", eoi_pulse, 0);
        commit();

        // R8: end of interrupt with nothing in service
        step(0, 0, 0, 1, 1, 0, 0);
        drive_chk(0, 0, 0, 0, 0, 0, 0);
        chk("R8", proc_prio, 8'h30);
        chk("R8", eoi_pulse, 0);
        commit();
        step(0, 0, 0, 1, 0, 8'h00, 0);

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] v;
            int r = int'($urandom % 100);
            v = ($urandom % 2 == 0) ? pick[$urandom % 8] : 8'($urandom);
            step(r < 55, v, 1'($urandom), r >= 80 && r < 97, r < 92,
                 8'(($urandom % 10) << 4), ($urandom % 10) < 7);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule